// File: doc/BRIEF.md
# Card Round Controller

This block is the top-level sequencer for a one-player-versus-dealer card game. It keeps a credit balance, takes a per-round bet from a switch bank, and steers a card source and two external hand scorers through a round: a four-card opening deal, the player's hit and stand decisions, the dealer's automatic drawing, and settlement of the bet against the balance. The game halts permanently once the balance falls to zero or climbs to the ceiling.

The scorers are external. They add each accepted card to the hand it was routed to, and they report a total, a bust flag and, for the player, a two-card 21 flag, all one cycle after the card is taken. The controller waits out that cycle before it acts on a total. Button inputs are level signals. The block edge-detects them, so a held button acts once. Display driving is not part of this block.

Top module: `card_round_ctrl`

## Requirements
- R1: After reset the state code is 0 (betting), the balance equals START_BAL (200 by default), the bet output is 0, draw_o, hole_shown_o, game_over_o and the three outcome flags are low.
- R2: In betting, a step press with bet_i equal to 0 keeps the state at 0. A step press with a nonzero bet_i latches that value into bet_o and moves to state 1 (dealing).
- R3: Each button acts only on a rising edge. A press held high for many cycles causes exactly one action.
- R4: A card is taken in any cycle where draw_o and card_valid_i are both high. In dealing, draw_o stays high until four cards are taken, routed player, dealer, player, dealer (draw_to_dealer_o = 0, 1, 0, 1). The block then enters state 2 (player turn).
- R5: In state 2, one hit press requests exactly one player card. If the player's bust flag is set, the bet is subtracted from the balance and play returns to state 0.
- R6: A stand press in state 2, or a set two-card 21 flag, moves to state 3 (dealer turn). hole_shown_o is high in states 3 and 4 and low otherwise.
- R7: In state 3 the block requests dealer cards while the dealer total is 16 or lower and not bust. Once the total reaches 17 or more, or the hand busts, it moves to state 4 (settle).
- R8: Settlement is a win (balance + bet) when the dealer busts or the player total is higher, a push (balance unchanged) on equal totals, and a loss (balance - bet) on a lower total or a player bust. Exactly one of win_o, lose_o and push_o is raised, and it is held until the next deal starts.
- R9: A balance update saturates at 0 and at MAX_BAL (1000 by default).
- R10: When the updated balance is 0 or MAX_BAL, the block enters state 5 with game_over_o high. From there, every button and bet input is ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Advance button (leave betting) |
| hit_i | input | 1 | Hit button |
| stand_i | input | 1 | Stand button |
| bet_i | input | BET_W | Bet switches |
| card_valid_i | input | 1 | Card source has a card ready |
| player_total_i | input | TOTAL_W | Player hand total from scorer |
| player_bust_i | input | 1 | Player total over 21 |
| player_natural_i | input | 1 | Player holds 21 with two cards |
| dealer_total_i | input | TOTAL_W | Dealer hand total from scorer |
| dealer_bust_i | input | 1 | Dealer total over 21 |
| draw_o | output | 1 | Card request |
| draw_to_dealer_o | output | 1 | Route requested card to dealer (1) or player (0) |
| hole_shown_o | output | 1 | Dealer's second card is revealed |
| bal_o | output | BAL_W | Credit balance |
| bet_o | output | BET_W | Latched bet of the current round |
| state_o | output | 3 | State code 0..5 |
| game_over_o | output | 1 | Game has ended |
| win_o | output | 1 | Last round won |
| lose_o | output | 1 | Last round lost |
| push_o | output | 1 | Last round pushed |

## Verification
The bench builds the block with START_BAL = 20 and MAX_BAL = 40. With these values a few maximum-size bets drive the balance past either limit. Both saturation points and both game-over exits are therefore reached in a short run, including a win that would overshoot the ceiling and a loss larger than the remaining balance. The remaining parameters keep their defaults, so the stand threshold of 17 and the 4-bit bet range are exercised as they ship.

// File: rtl/card_round_pkg.sv
`timescale 1ns/1ps
package card_round_pkg;

  typedef enum logic [2:0] {
    RS_BET    = 3'd0,
    RS_DEAL   = 3'd1,
    RS_PLAY   = 3'd2,
    RS_DEALER = 3'd3,
    RS_SETTLE = 3'd4,
    RS_OVER   = 3'd5
  } round_state_t;

  typedef enum logic [1:0] {
    OC_NONE = 2'd0,
    OC_WIN  = 2'd1,
    OC_LOSE = 2'd2,
    OC_PUSH = 2'd3
  } outcome_t;

  localparam int unsigned BTN_N = 3;
  localparam int unsigned BTN_STEP  = 0;
  localparam int unsigned BTN_HIT   = 1;
  localparam int unsigned BTN_STAND = 2;

endpackage

// File: rtl/btn_edge.sv
`timescale 1ns/1ps
module btn_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  for (genvar g = 0; g < N; g++) begin : g_btn
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q;
  end

endmodule

// File: rtl/round_judge.sv
`timescale 1ns/1ps
module round_judge
  import card_round_pkg::*;
#(
  parameter int unsigned TOTAL_W = 5
) (
  input  logic [TOTAL_W-1:0] p_tot_i,
  input  logic [TOTAL_W-1:0] d_tot_i,
  input  logic               p_bust_i,
  input  logic               d_bust_i,
  output outcome_t           outcome_o
);

  always_comb begin
    if (p_bust_i)                outcome_o = OC_LOSE;
    else if (d_bust_i)           outcome_o = OC_WIN;
    else if (p_tot_i > d_tot_i)  outcome_o = OC_WIN;
    else if (p_tot_i == d_tot_i) outcome_o = OC_PUSH;
    else                         outcome_o = OC_LOSE;
  end

endmodule

// File: rtl/bal_update.sv
`timescale 1ns/1ps
module bal_update
  import card_round_pkg::*;
#(
  parameter int unsigned BAL_W   = 10,
  parameter int unsigned BET_W   = 4,
  parameter int unsigned MAX_BAL = 1000
) (
  input  logic [BAL_W-1:0] bal_i,
  input  logic [BET_W-1:0] bet_i,
  input  outcome_t         outcome_i,
  output logic [BAL_W-1:0] bal_o
);

  localparam int unsigned EXT_W = BAL_W + 1;
  localparam logic [EXT_W-1:0] CEIL = EXT_W'(MAX_BAL);

  logic [EXT_W-1:0] bal_x, bet_x, sum_x;

  assign bal_x = EXT_W'(bal_i);
  assign bet_x = EXT_W'(bet_i);
  assign sum_x = bal_x + bet_x;

  always_comb begin
    unique case (outcome_i)
      OC_WIN:  bal_o = (sum_x > CEIL) ? BAL_W'(MAX_BAL) : sum_x[BAL_W-1:0];
      OC_LOSE: bal_o = (bet_x >= bal_x) ? '0 : BAL_W'(bal_x - bet_x);
      default: bal_o = bal_i;
    endcase
  end

endmodule

// File: rtl/card_round_ctrl.sv
`timescale 1ns/1ps
module card_round_ctrl
  import card_round_pkg::*;
#(
  parameter int unsigned START_BAL    = 200,
  parameter int unsigned MAX_BAL      = 1000,
  parameter int unsigned BET_W        = 4,
  parameter int unsigned TOTAL_W      = 5,
  parameter int unsigned DEALER_STAND = 17,
  localparam int unsigned BAL_W       = $clog2(MAX_BAL + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               hit_i,
  input  logic               stand_i,
  input  logic [BET_W-1:0]   bet_i,
  input  logic               card_valid_i,
  input  logic [TOTAL_W-1:0] player_total_i,
  input  logic               player_bust_i,
  input  logic               player_natural_i,
  input  logic [TOTAL_W-1:0] dealer_total_i,
  input  logic               dealer_bust_i,
  output logic               draw_o,
  output logic               draw_to_dealer_o,
  output logic               hole_shown_o,
  output logic [BAL_W-1:0]   bal_o,
  output logic [BET_W-1:0]   bet_o,
  output logic [2:0]         state_o,
  output logic               game_over_o,
  output logic               win_o,
  output logic               lose_o,
  output logic               push_o
);

  localparam int unsigned DEAL_CARDS = 4;
  localparam int unsigned DC_W = $clog2(DEAL_CARDS);

  round_state_t       state_q;
  logic [BAL_W-1:0]   bal_q, bal_nxt;
  logic [BET_W-1:0]   bet_q;
  logic [DC_W-1:0]    deal_cnt_q;
  logic               card_pend_q, hit_req_q;
  logic               win_q, lose_q, push_q;
  logic [BTN_N-1:0]   btn_lvl, btn_rise;
  logic               step_e, hit_e, stand_e;
  logic               accept, dealer_done, play_idle;
  outcome_t           outcome;

  assign btn_lvl = {stand_i, hit_i, step_i};

  btn_edge #(.N(BTN_N)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (btn_lvl),
    .rise_o (btn_rise)
  );

  assign step_e  = btn_rise[BTN_STEP];
  assign hit_e   = btn_rise[BTN_HIT];
  assign stand_e = btn_rise[BTN_STAND];

  round_judge #(.TOTAL_W(TOTAL_W)) u_judge (
    .p_tot_i   (player_total_i),
    .d_tot_i   (dealer_total_i),
    .p_bust_i  (player_bust_i),
    .d_bust_i  (dealer_bust_i),
    .outcome_o (outcome)
  );

  bal_update #(.BAL_W(BAL_W), .BET_W(BET_W), .MAX_BAL(MAX_BAL)) u_bal (
    .bal_i     (bal_q),
    .bet_i     (bet_q),
    .outcome_i (outcome),
    .bal_o     (bal_nxt)
  );

  assign dealer_done = dealer_bust_i || (dealer_total_i >= TOTAL_W'(DEALER_STAND));
  assign play_idle   = !card_pend_q && !hit_req_q;

  always_comb begin
    draw_o           = 1'b0;
    draw_to_dealer_o = 1'b0;
    unique case (state_q)
      RS_DEAL: begin
        draw_o           = 1'b1;
        draw_to_dealer_o = deal_cnt_q[0];
      end
      RS_PLAY: draw_o = hit_req_q;
      RS_DEALER: begin
        draw_o           = !card_pend_q && !dealer_done;
        draw_to_dealer_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign accept = draw_o && card_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RS_BET;
      bal_q       <= BAL_W'(START_BAL);
      bet_q       <= '0;
      deal_cnt_q  <= '0;
      card_pend_q <= 1'b0;
      hit_req_q   <= 1'b0;
      win_q       <= 1'b0;
      lose_q      <= 1'b0;
      push_q      <= 1'b0;
    end else begin
      card_pend_q <= accept;
      unique case (state_q)
        RS_BET: if (step_e && bet_i != '0) begin
          state_q    <= RS_DEAL;
          bet_q      <= bet_i;
          deal_cnt_q <= '0;
          hit_req_q  <= 1'b0;
          win_q      <= 1'b0;
          lose_q     <= 1'b0;
          push_q     <= 1'b0;
        end
        RS_DEAL: if (accept) begin
          deal_cnt_q <= deal_cnt_q + 1'b1;
          if (deal_cnt_q == DC_W'(DEAL_CARDS - 1)) state_q <= RS_PLAY;
        end
        RS_PLAY: begin
          if (accept) hit_req_q <= 1'b0;
          else if (play_idle) begin
            // totals are only trusted once the scorer has absorbed the last card
            if (player_bust_i)         state_q   <= RS_SETTLE;
            else if (player_natural_i) state_q   <= RS_DEALER;
            else if (stand_e)          state_q   <= RS_DEALER;
            else if (hit_e)            hit_req_q <= 1'b1;
          end
        end
        RS_DEALER: if (!card_pend_q && dealer_done) state_q <= RS_SETTLE;
        RS_SETTLE: begin
          bal_q  <= bal_nxt;
          win_q  <= (outcome == OC_WIN);
          lose_q <= (outcome == OC_LOSE);
          push_q <= (outcome == OC_PUSH);
          state_q <= (bal_nxt == '0 || bal_nxt == BAL_W'(MAX_BAL)) ? RS_OVER : RS_BET;
        end
        RS_OVER: ;
        default: state_q <= RS_BET;
      endcase
    end
  end

  assign bal_o        = bal_q;
  assign bet_o        = bet_q;
  assign state_o      = state_q;
  assign game_over_o  = (state_q == RS_OVER);
  assign hole_shown_o = (state_q == RS_DEALER) || (state_q == RS_SETTLE);
  assign win_o        = win_q;
  assign lose_o       = lose_q;
  assign push_o       = push_q;

  // R2
  zero_bet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RS_BET && bet_i == '0) |=> state_q != RS_DEAL);

  // R7
  dealer_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RS_DEALER && !card_pend_q && dealer_done) |=> state_q == RS_SETTLE);

  // R8
  outcome_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({win_q, lose_q, push_q}));

  // R9
  bal_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bal_q <= BAL_W'(MAX_BAL));

  // R10
  over_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == RS_OVER |=> (state_q == RS_OVER && $stable(bal_q)));

endmodule

// File: tb/test_card_round_ctrl.sv
`timescale 1ns/1ps
module test_card_round_ctrl;

  localparam int SB = 20;
  localparam int MB = 40;
  localparam int DS = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, hit = 1'b0, stand = 1'b0, stall = 1'b0;
  logic [3:0] bet = '0;
  logic card_valid;
  logic draw, to_dealer, hole, over, win, lose, push;
  logic [5:0] bal;
  logic [3:0] bet_out;
  logic [2:0] st;

  int cards [0:63];
  int wr = 0, rd = 0;
  int ptot = 0, pcnt = 0, dtot = 0;
  int dut_cards = 0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_state, m_bal, m_bet, m_dc;
  bit m_pend, m_hitreq, m_w, m_l, m_p, m_sq, m_hq, m_tq;

  always #4 clk = ~clk;

  assign card_valid = (wr != rd) && !stall;

  card_round_ctrl #(.START_BAL(SB), .MAX_BAL(MB)) i_card_round_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .hit_i(hit), .stand_i(stand),
    .bet_i(bet), .card_valid_i(card_valid),
    .player_total_i(5'(ptot)), .player_bust_i(ptot > 21),
    .player_natural_i(ptot == 21 && pcnt == 2),
    .dealer_total_i(5'(dtot)), .dealer_bust_i(dtot > 21),
    .draw_o(draw), .draw_to_dealer_o(to_dealer), .hole_shown_o(hole),
    .bal_o(bal), .bet_o(bet_out), .state_o(st), .game_over_o(over),
    .win_o(win), .lose_o(lose), .push_o(push)
  );

  function automatic bit m_draw();
    case (m_state)
      1: return 1'b1;
      2: return m_hitreq;
      3: return !m_pend && !(dtot > 21 || dtot >= DS);
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_dest();
    return (m_state == 1) ? m_dc[0] : (m_state == 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_bal <= SB; m_bet <= 0; m_dc <= 0;
      m_pend <= 0; m_hitreq <= 0; m_w <= 0; m_l <= 0; m_p <= 0;
      m_sq <= 0; m_hq <= 0; m_tq <= 0;
    end else begin
      bit acc, se, he, te;
      int nb;
      acc = m_draw() && card_valid;
      se = step && !m_sq; he = hit && !m_hq; te = stand && !m_tq;
      m_sq <= step; m_hq <= hit; m_tq <= stand;
      m_pend <= acc;
      if (acc) begin
        rd <= rd + 1;
        if (m_dest()) dtot <= dtot + cards[rd[5:0]];
        else begin ptot <= ptot + cards[rd[5:0]]; pcnt <= pcnt + 1; end
      end
      case (m_state)
        0: if (se && bet != 0) begin
          m_state <= 1; m_bet <= int'(bet); m_dc <= 0; m_hitreq <= 0;
          m_w <= 0; m_l <= 0; m_p <= 0;
        end
        1: if (acc) begin m_dc <= m_dc + 1; if (m_dc == 3) m_state <= 2; end
        2: if (acc) m_hitreq <= 0;
           else if (!m_pend && !m_hitreq) begin
             if (ptot > 21) m_state <= 4;
             else if (ptot == 21 && pcnt == 2) m_state <= 3;
             else if (te) m_state <= 3;
             else if (he) m_hitreq <= 1;
           end
        3: if (!m_pend && (dtot > 21 || dtot >= DS)) m_state <= 4;
        4: begin
          int oc; // 1 win 2 lose 3 push
          if (ptot > 21) oc = 2;
          else if (dtot > 21) oc = 1;
          else if (ptot > dtot) oc = 1;
          else if (ptot == dtot) oc = 3;
          else oc = 2;
          nb = m_bal;
          if (oc == 1) nb = (m_bal + m_bet > MB) ? MB : m_bal + m_bet;
          if (oc == 2) nb = (m_bet >= m_bal) ? 0 : m_bal - m_bet;
          m_bal <= nb; m_w <= (oc == 1); m_l <= (oc == 2); m_p <= (oc == 3);
          m_state <= (nb == 0 || nb == MB) ? 5 : 0;
        end
        default: ;
      endcase
    end
  end

  always @(posedge clk) if (rst_n && draw && card_valid) dut_cards <= dut_cards + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk(int'(st) == m_state, "R2/R4/R6 state", int'(st), m_state);
    chk(int'(bal) == m_bal, "R8/R9 balance", int'(bal), m_bal);
    chk(int'(bet_out) == m_bet, "R2 bet", int'(bet_out), m_bet);
    chk(draw == m_draw(), "R4/R5/R7 draw", int'(draw), int'(m_draw()));
    if (draw) chk(to_dealer == m_dest(), "R4 route", int'(to_dealer), int'(m_dest()));
    chk({win, lose, push} == {m_w, m_l, m_p}, "R8 outcome", int'({win, lose, push}), int'({m_w, m_l, m_p}));
    chk(over == (m_state == 5), "R10 over", int'(over), int'(m_state == 5));
    chk(hole == (m_state == 3 || m_state == 4), "R6 hole", int'(hole), int'(m_state == 3 || m_state == 4));
  end

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic push_card(input int v); cards[wr[5:0]] = v; wr++; endtask

  task automatic pulse(ref logic b);
    b = 1'b1; tick(); b = 1'b0; tick();
  endtask

  task automatic wait_state(input int s);
    int n = 0;
    while (m_state != s && n < 500) begin tick(); n++; end
    if (n >= 500) chk(0, "wait", m_state, s);
  endtask

  task automatic wait_play_idle();
    int n = 0;
    while (!(m_state == 2 && !m_pend && !m_hitreq) && n < 500) begin tick(); n++; end
    if (n >= 500) chk(0, "wait_idle", m_state, 2);
  endtask

  task automatic start_round(input int b, input int c0, input int c1, input int c2, input int c3);
    ptot = 0; pcnt = 0; dtot = 0; dut_cards = 0;
    push_card(c0); push_card(c1); push_card(c2); push_card(c3);
    bet = 4'(b);
    pulse(step);
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset values
    chk(st == 3'd0, "R1 state", int'(st), 0);
    chk(bal == 6'(SB), "R1 balance", int'(bal), SB);
    chk(bet_out == 0 && !draw && !win && !lose && !push && !over && !hole, "R1 outputs", 0, 0);
    rst_n = 1'b1; tick();

    // R2 zero bet does not leave betting
    bet = 4'd0; pulse(step); repeat (3) tick();
    chk(st == 3'd0, "R2 zero bet held", int'(st), 0);

    // R4/R6/R8 plain win 19 vs 17, bet 5 -> 25
    start_round(5, 10, 9, 9, 8);
    chk(st == 3'd1, "R2 enter deal", int'(st), 1);
    wait_play_idle();
    chk(dut_cards == 4, "R4 four dealt", dut_cards, 4);
    chk(!hole, "R6 hole hidden in play", int'(hole), 0);
    pulse(stand); wait_state(0);
    chk(bal == 6'd25 && win, "R8 win", int'(bal), 25);

    // R5 bust after hit, bet 7 -> 18
    start_round(7, 10, 5, 6, 6);
    wait_play_idle(); push_card(9); pulse(hit); wait_state(0);
    chk(bal == 6'd18 && lose, "R5 bust deducts", int'(bal), 18);

    // R7 dealer draws 10 -> 15 -> 18, push at 18, bet 3
    start_round(3, 10, 6, 8, 4);
    wait_play_idle(); push_card(5); push_card(3); pulse(stand); wait_state(0);
    chk(dut_cards == 6, "R7 dealer drew two", dut_cards, 6);
    chk(bal == 6'd18 && push, "R8 push", int'(bal), 18);

    // R8 dealer bust is a win, bet 4 -> 22
    start_round(4, 10, 10, 2, 6);
    wait_play_idle(); push_card(10); pulse(stand); wait_state(0);
    chk(bal == 6'd22 && win, "R8 dealer bust win", int'(bal), 22);

    // R6 two-card 21 skips to dealer, bet 2 -> 24
    start_round(2, 11, 10, 10, 7);
    wait_state(3);
    chk(hole, "R6 natural reveals", int'(hole), 1);
    wait_state(0);
    chk(bal == 6'd24 && win, "R6 natural win", int'(bal), 24);

    // R8 lower total loses, bet 1 -> 23
    start_round(1, 10, 10, 7, 8);
    wait_play_idle(); pulse(stand); wait_state(0);
    chk(bal == 6'd23 && lose, "R8 lower loses", int'(bal), 23);

    // R3/R4 stalled deal, then held hit gives one card, bet 6 -> 29
    ptot = 0; pcnt = 0; dtot = 0; dut_cards = 0;
    push_card(5); push_card(10); push_card(5); push_card(7);
    bet = 4'd6; stall = 1'b1; pulse(step); repeat (4) tick();
    chk(st == 3'd1 && !card_valid, "R4 waits for card", int'(st), 1);
    stall = 1'b0;
    wait_play_idle(); push_card(9); push_card(9);
    hit = 1'b1; repeat (12) tick(); hit = 1'b0; tick();
    chk(dut_cards == 5, "R3 held hit one card", dut_cards, 5);
    pulse(stand); wait_state(0);
    chk(bal == 6'd29 && win, "R5 hit then win", int'(bal), 29);
    rd = wr; // drop unused card

    // R9/R10 win overshoots ceiling: 29+15 -> 40
    start_round(15, 10, 10, 9, 8);
    wait_play_idle(); pulse(stand); wait_state(5);
    tick();
    chk(bal == 6'(MB), "R9 ceiling saturation", int'(bal), MB);
    chk(over, "R10 over at ceiling", int'(over), 1);
    bet = 4'd3; pulse(step); pulse(hit); pulse(stand); repeat (3) tick();
    chk(st == 3'd5 && bal == 6'(MB), "R10 inputs ignored", int'(st), 5);

    // R1 reset restores, then drain to 0
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    chk(bal == 6'(SB) && st == 3'd0, "R1 reset restores", int'(bal), SB);
    start_round(15, 10, 10, 7, 10);
    wait_play_idle(); pulse(stand); wait_state(0);
    chk(bal == 6'd5, "R8 loss", int'(bal), 5);
    start_round(15, 10, 10, 7, 10);
    wait_play_idle(); pulse(stand); wait_state(5);
    tick();
    chk(bal == 6'd0 && over, "R9 floor saturation", int'(bal), 0);
    chk(lose, "R10 over at zero", int'(lose), 1);
    repeat (4) tick();
    finish_run();
  end

endmodule